// File: doc/BRIEF.md
# Host Parallel Mailbox

This block sits between an external host processor and an embedded modem controller. It gives the host a byte-wide window of two registers. The data register carries bytes in both directions, such as command text going one way and responses coming back. The status register holds the handshake flags, the interrupt enables, the line-break bits and the modem control lines. On the host side the block takes chip select, read strobe, write strobe, one address line and a parallel/serial mode select. On the controller side the controller loads received bytes, takes transmitted bytes and drives its own carrier and break indications.

Host control and data inputs pass through a synchronizer. Each host access takes effect once, at the synchronized falling edge of its strobe. Two flags manage the flow of bytes. The receive-full flag tells the host that a byte is waiting. The transmit-empty flag tells the host that it may write. Each flag has its own enable, and both feed one shared active-low interrupt. The block does not time line breaks. It only carries the break request and the break indication between the two sides.

Top module: `host_mailbox`

## Requirements
- R1: While reset is held and just after it ends, the status byte reads 0x21: only DCD (bit 5) and transmit-empty (bit 0) are 1. At the same time host_irq_n is 1, host_dout is 0, and ctl_tx_empty, ctl_rx_full, ctl_dtr and ctl_sbrk show the reset flag values.
- R2: A data write is host_addr=0 with cs, wr and ser_sel low. It latches host_din onto ctl_tx_byte and clears transmit-empty (bit 0). A ctl_tx_take pulse sets transmit-empty again.
- R3: A ctl_rx_load pulse stores ctl_rx_byte and sets receive-full (bit 1). A data read is host_addr=0 with cs, rd and ser_sel low. It drives the stored byte on host_dout, and its strobe's falling edge clears receive-full.
- R4: With host_addr=1 a read returns the status byte. Its bits, from 7 down to 0, are: receive irq enable, transmit irq enable, DCD, receive-break, DTR, send-break, receive-full, transmit-empty.
- R5: A status write updates only bits 7, 6, 3 and 2. The values written to bits 5, 4, 1 and 0 are ignored.
- R6: host_irq_n is 0 exactly when (receive-full and bit 7) or (transmit-empty and bit 6) holds, one cycle after the status changes.
- R7: host_dout is 0 whenever no valid read is in progress, that is, whenever cs, rd or ser_sel is high.
- R8: An access made with ser_sel high changes no register.
- R9: Each strobe acts once. A data read held low across a later ctl_rx_load leaves receive-full set and shows the new byte.
- R10: Bit 4 follows ctl_rbrk. The host's bit 2 appears unchanged on ctl_sbrk until the host rewrites it.
- R11: The host's bit 3 appears on ctl_dtr, and bit 5 follows ctl_dcd.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| host_cs_n | input | 1 | Host chip select, active low |
| host_rd_n | input | 1 | Host read strobe, active low |
| host_wr_n | input | 1 | Host write strobe, active low |
| host_addr | input | 1 | Register select: 0 data, 1 status |
| host_ser_sel | input | 1 | Mode select; low enables the parallel port |
| host_din | input | DW | Host write data |
| host_dout | output | DW | Host read data, zero when idle |
| host_irq_n | output | 1 | Interrupt to host, active low |
| ctl_rx_load | input | 1 | Controller loads a byte for the host |
| ctl_rx_byte | input | DW | Byte loaded for the host |
| ctl_tx_take | input | 1 | Controller has taken the host's byte |
| ctl_tx_byte | output | DW | Last byte written by the host |
| ctl_dcd | input | 1 | Carrier detect from the controller |
| ctl_rbrk | input | 1 | Line break being delivered to host |
| ctl_rx_full | output | 1 | Receive-full flag |
| ctl_tx_empty | output | 1 | Transmit-empty flag |
| ctl_dtr | output | 1 | DTR set by the host |
| ctl_sbrk | output | 1 | Send-break request from the host |

## Verification
A flag left in the wrong state shows up at the ports in two ways. It appears in the next status read. It also appears one cycle later on host_irq_n, provided its enable is set. A strobe that acts twice, or that acts on a level rather than an edge, leaves receive-full clear after a load made during a long read, and the next status read shows it. A write decode that lets read-only bits through changes the DCD or flag bits in the read that follows. A stale read path leaves a non-zero value on host_dout after the strobes rise.

// File: rtl/hmb_pkg.sv
package hmb_pkg;
  localparam int BIT_RX_IE = 7;
  localparam int BIT_TX_IE = 6;
  localparam int BIT_DCD   = 5;
  localparam int BIT_RBRK  = 4;
  localparam int BIT_DTR   = 3;
  localparam int BIT_SBRK  = 2;
  localparam int BIT_RXF   = 1;
  localparam int BIT_TXE   = 0;
  localparam int STAT_W    = 8;

  typedef enum logic {
    SEL_DATA   = 1'b0,
    SEL_STATUS = 1'b1
  } reg_sel_e;
endpackage

// File: rtl/hmb_host_sync.sv
module hmb_host_sync #(
  parameter int DW          = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  cs_n,
  input  logic                  rd_n,
  input  logic                  wr_n,
  input  logic                  addr,
  input  logic                  ser_sel,
  input  logic [DW-1:0]         din,
  output logic                  rd_evt,
  output logic                  wr_evt,
  output logic                  rd_active,
  output hmb_pkg::reg_sel_e     sel,
  output logic [DW-1:0]         din_s
);
  localparam int VW = DW + 5;
  // idle: cs/rd/wr high, addr low, ser high, data zero
  localparam logic [VW-1:0] IDLE = {{DW{1'b0}}, 5'b11101};

  logic [SYNC_STAGES-1:0][VW-1:0] stg;
  logic [VW-1:0] s;
  logic s_cs, s_rd, s_wr, s_addr, s_ser;
  logic prev_rd, prev_wr;

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < SYNC_STAGES; i++) stg[i] <= IDLE;
    end else begin
      stg[0] <= {din, cs_n, rd_n, wr_n, addr, ser_sel};
      for (int i = 1; i < SYNC_STAGES; i++) stg[i] <= stg[i-1];
    end
  end

  assign s = stg[SYNC_STAGES-1];
  assign {din_s, s_cs, s_rd, s_wr, s_addr, s_ser} = s;

  always_ff @(posedge clk) begin
    if (rst) begin
      prev_rd <= 1'b1;
      prev_wr <= 1'b1;
    end else begin
      prev_rd <= s_rd;
      prev_wr <= s_wr;
    end
  end

  assign rd_active = ~s_rd & ~s_cs & ~s_ser;
  assign rd_evt    = prev_rd & rd_active;
  assign wr_evt    = prev_wr & ~s_wr & ~s_cs & ~s_ser;
  assign sel       = hmb_pkg::reg_sel_e'(s_addr);

  assert_rd_once_R9: assert property (@(posedge clk) disable iff (rst)
    rd_evt |=> !rd_evt);
  assert_wr_once_R9: assert property (@(posedge clk) disable iff (rst)
    wr_evt |=> !wr_evt);
endmodule

// File: rtl/hmb_regs.sv
module hmb_regs #(
  parameter int DW = 8
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      rd_evt,
  input  logic                      wr_evt,
  input  logic                      rd_active,
  input  hmb_pkg::reg_sel_e         sel,
  input  logic [DW-1:0]             din_s,
  input  logic                      ctl_rx_load,
  input  logic [DW-1:0]             ctl_rx_byte,
  input  logic                      ctl_tx_take,
  input  logic                      ctl_dcd,
  input  logic                      ctl_rbrk,
  output logic [hmb_pkg::STAT_W-1:0] status,
  output logic [DW-1:0]             tx_byte,
  output logic [DW-1:0]             dout
);
  import hmb_pkg::*;

  logic rx_ie, tx_ie, dtr, sbrk, dcd_q, rbrk_q, rx_full, tx_empty;
  logic [DW-1:0] rx_byte;
  logic stat_wr, data_wr, data_rd;

  assign stat_wr = wr_evt && (sel == SEL_STATUS);
  assign data_wr = wr_evt && (sel == SEL_DATA);
  assign data_rd = rd_evt && (sel == SEL_DATA);

  // host-owned bits
  always_ff @(posedge clk) begin
    if (rst) begin
      rx_ie <= 1'b0;
      tx_ie <= 1'b0;
      dtr   <= 1'b0;
      sbrk  <= 1'b0;
    end else if (stat_wr) begin
      rx_ie <= din_s[BIT_RX_IE];
      tx_ie <= din_s[BIT_TX_IE];
      dtr   <= din_s[BIT_DTR];
      sbrk  <= din_s[BIT_SBRK];
    end
  end

  // controller-owned bits
  always_ff @(posedge clk) begin
    if (rst) begin
      dcd_q  <= 1'b1;
      rbrk_q <= 1'b0;
    end else begin
      dcd_q  <= ctl_dcd;
      rbrk_q <= ctl_rbrk;
    end
  end

  // handshake flags: a new event from the filling side wins
  always_ff @(posedge clk) begin
    if (rst) begin
      rx_full  <= 1'b0;
      tx_empty <= 1'b1;
    end else begin
      if (ctl_rx_load)  rx_full <= 1'b1;
      else if (data_rd) rx_full <= 1'b0;
      if (data_wr)          tx_empty <= 1'b0;
      else if (ctl_tx_take) tx_empty <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rx_byte <= '0;
      tx_byte <= '0;
    end else begin
      if (ctl_rx_load) rx_byte <= ctl_rx_byte;
      if (data_wr)     tx_byte <= din_s;
    end
  end

  always_comb begin
    status            = '0;
    status[BIT_RX_IE] = rx_ie;
    status[BIT_TX_IE] = tx_ie;
    status[BIT_DCD]   = dcd_q;
    status[BIT_RBRK]  = rbrk_q;
    status[BIT_DTR]   = dtr;
    status[BIT_SBRK]  = sbrk;
    status[BIT_RXF]   = rx_full;
    status[BIT_TXE]   = tx_empty;
  end

  always_ff @(posedge clk) begin
    if (rst)                    dout <= '0;
    else if (!rd_active)        dout <= '0;
    else if (sel == SEL_STATUS) dout <= DW'(status);
    else                        dout <= rx_byte;
  end

  assert_rx_set_R3: assert property (@(posedge clk) disable iff (rst)
    ctl_rx_load |=> rx_full);
  assert_rx_clr_R3: assert property (@(posedge clk) disable iff (rst)
    (data_rd && !ctl_rx_load) |=> !rx_full);
  assert_tx_clr_R2: assert property (@(posedge clk) disable iff (rst)
    data_wr |=> !tx_empty);
  assert_dcd_ro_R5: assert property (@(posedge clk) disable iff (rst)
    stat_wr |=> dcd_q == $past(ctl_dcd));
  assert_dout_idle_R7: assert property (@(posedge clk) disable iff (rst)
    !rd_active |=> dout == '0);
endmodule

// File: rtl/hmb_irq.sv
module hmb_irq (
  input  logic clk,
  input  logic rst,
  input  logic rx_full,
  input  logic tx_empty,
  input  logic rx_ie,
  input  logic tx_ie,
  output logic irq_n
);
  always_ff @(posedge clk) begin
    if (rst) irq_n <= 1'b1;
    else     irq_n <= ~((rx_full & rx_ie) | (tx_empty & tx_ie));
  end

  assert_irq_quiet_R6: assert property (@(posedge clk) disable iff (rst)
    !(rx_ie || tx_ie) |=> irq_n);
endmodule

// File: rtl/host_mailbox.sv
module host_mailbox #(
  parameter int DW          = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          host_cs_n,
  input  logic          host_rd_n,
  input  logic          host_wr_n,
  input  logic          host_addr,
  input  logic          host_ser_sel,
  input  logic [DW-1:0] host_din,
  output logic [DW-1:0] host_dout,
  output logic          host_irq_n,
  input  logic          ctl_rx_load,
  input  logic [DW-1:0] ctl_rx_byte,
  input  logic          ctl_tx_take,
  output logic [DW-1:0] ctl_tx_byte,
  input  logic          ctl_dcd,
  input  logic          ctl_rbrk,
  output logic          ctl_rx_full,
  output logic          ctl_tx_empty,
  output logic          ctl_dtr,
  output logic          ctl_sbrk
);
  import hmb_pkg::*;

  logic rd_evt, wr_evt, rd_active;
  reg_sel_e sel;
  logic [DW-1:0] din_s;
  logic [STAT_W-1:0] status;

  hmb_host_sync #(.DW(DW), .SYNC_STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .cs_n(host_cs_n), .rd_n(host_rd_n),
    .wr_n(host_wr_n), .addr(host_addr), .ser_sel(host_ser_sel),
    .din(host_din), .rd_evt(rd_evt), .wr_evt(wr_evt),
    .rd_active(rd_active), .sel(sel), .din_s(din_s)
  );

  hmb_regs #(.DW(DW)) u_regs (
    .clk(clk), .rst(rst), .rd_evt(rd_evt), .wr_evt(wr_evt),
    .rd_active(rd_active), .sel(sel), .din_s(din_s),
    .ctl_rx_load(ctl_rx_load), .ctl_rx_byte(ctl_rx_byte),
    .ctl_tx_take(ctl_tx_take), .ctl_dcd(ctl_dcd), .ctl_rbrk(ctl_rbrk),
    .status(status), .tx_byte(ctl_tx_byte), .dout(host_dout)
  );

  hmb_irq u_irq (
    .clk(clk), .rst(rst),
    .rx_full(status[BIT_RXF]), .tx_empty(status[BIT_TXE]),
    .rx_ie(status[BIT_RX_IE]), .tx_ie(status[BIT_TX_IE]),
    .irq_n(host_irq_n)
  );

  assign ctl_rx_full  = status[BIT_RXF];
  assign ctl_tx_empty = status[BIT_TXE];
  assign ctl_dtr      = status[BIT_DTR];
  assign ctl_sbrk     = status[BIT_SBRK];

  assert_ser_no_wr_R8: assert property (@(posedge clk) disable iff (rst)
    (host_ser_sel && $past(host_ser_sel) && !ctl_tx_take) |=> $stable(ctl_tx_byte));
  assert_irq_rx_R6: assert property (@(posedge clk) disable iff (rst)
    (ctl_rx_full && status[BIT_RX_IE]) |=> !host_irq_n);
endmodule

// File: tb/host_mailbox_tb.sv
module host_mailbox_tb;
  localparam int DW = 8;
  localparam int K_DOUT = 0, K_IRQ = 1, K_TXB = 2, K_TXE = 3, K_RXF = 4, K_DTR = 5, K_SBRK = 6;

  typedef struct {
    int         kind;
    logic [7:0] exp;
    string      req;
  } item_t;

  logic clk = 0, rst = 1;
  logic cs_n = 1, rd_n = 1, wr_n = 1, addr = 0, ser = 0;
  logic [DW-1:0] din = '0, dout, rx_byte = '0, tx_byte;
  logic irq_n, rx_load = 0, tx_take = 0, dcd = 1, rbrk = 0;
  logic rx_full, tx_empty, dtr, sbrk;

  item_t q[$];
  int n_chk = 0, n_fail = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  host_mailbox #(.DW(DW), .SYNC_STAGES(2)) u_dut (
    .clk(clk), .rst(rst), .host_cs_n(cs_n), .host_rd_n(rd_n),
    .host_wr_n(wr_n), .host_addr(addr), .host_ser_sel(ser),
    .host_din(din), .host_dout(dout), .host_irq_n(irq_n),
    .ctl_rx_load(rx_load), .ctl_rx_byte(rx_byte), .ctl_tx_take(tx_take),
    .ctl_tx_byte(tx_byte), .ctl_dcd(dcd), .ctl_rbrk(rbrk),
    .ctl_rx_full(rx_full), .ctl_tx_empty(tx_empty), .ctl_dtr(dtr),
    .ctl_sbrk(sbrk)
  );

  // monitor: pops expected items and compares at the falling edge
  initial begin
    forever begin
      @(negedge clk);
      while (q.size() > 0) begin
        item_t it;
        logic [7:0] act;
        it = q.pop_front();
        case (it.kind)
          K_DOUT:  act = dout;
          K_IRQ:   act = {7'd0, irq_n};
          K_TXB:   act = tx_byte;
          K_TXE:   act = {7'd0, tx_empty};
          K_RXF:   act = {7'd0, rx_full};
          K_DTR:   act = {7'd0, dtr};
          default: act = {7'd0, sbrk};
        endcase
        n_chk++;
        if (act !== it.exp) begin
          n_fail++;
          $display("FAIL %s kind=%0d actual=%02h expected=%02h", it.req, it.kind, act, it.exp);
        end
      end
    end
  end

  task automatic expect_(input int kind, input logic [7:0] v, input string req);
    item_t it;
    it.kind = kind; it.exp = v; it.req = req;
    q.push_back(it);
  endtask

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic host_write(input logic a, input logic [7:0] d);
    cs_n = 0; addr = a; din = d; tick(1);
    wr_n = 0; tick(5);
    wr_n = 1; tick(1);
    cs_n = 1; tick(4);
  endtask

  // read and check host_dout while the strobe is low
  task automatic host_read(input logic a, input logic [7:0] e, input string req);
    cs_n = 0; addr = a; tick(1);
    rd_n = 0; tick(5);
    expect_(K_DOUT, e, req);
    rd_n = 1; tick(1);
    cs_n = 1; tick(4);
  endtask

  task automatic ctl_load(input logic [7:0] b);
    rx_byte = b; rx_load = 1; tick(1);
    rx_load = 0; tick(2);
  endtask

  task automatic ctl_take();
    tx_take = 1; tick(1);
    tx_take = 0; tick(2);
  endtask

  initial begin
    tick(3);
    // R1: values during reset
    expect_(K_IRQ, 8'h01, "R1");
    expect_(K_TXE, 8'h01, "R1");
    expect_(K_RXF, 8'h00, "R1");
    expect_(K_DOUT, 8'h00, "R1");
    expect_(K_DTR, 8'h00, "R1");
    expect_(K_SBRK, 8'h00, "R1");
    rst = 0; tick(2);
    host_read(1'b1, 8'h21, "R1 R4 reset status");

    // R2: data write and controller take
    host_write(1'b0, 8'hA5);
    expect_(K_TXB, 8'hA5, "R2");
    expect_(K_TXE, 8'h00, "R2");
    host_read(1'b1, 8'h20, "R2 R4");
    ctl_take();
    expect_(K_TXE, 8'h01, "R2 take");

    // R8: serial mode write ignored
    ser = 1; host_write(1'b0, 8'h3C); ser = 0;
    expect_(K_TXB, 8'hA5, "R8");
    expect_(K_TXE, 8'h01, "R8");

    // R3: load and read
    ctl_load(8'h5A);
    expect_(K_RXF, 8'h01, "R3");
    host_read(1'b1, 8'h23, "R3 R4");
    host_read(1'b0, 8'h5A, "R3 data");
    expect_(K_RXF, 8'h00, "R3 clear");
    host_read(1'b1, 8'h21, "R3 status after");

    // R7: no valid read cycle
    rd_n = 0; tick(5);
    expect_(K_DOUT, 8'h00, "R7 cs high");
    cs_n = 0; ser = 1; tick(5);
    expect_(K_DOUT, 8'h00, "R7 ser high");
    rd_n = 1; cs_n = 1; ser = 0; tick(4);
    expect_(K_DOUT, 8'h00, "R7 idle");

    // R5/R6/R10/R11: write all status bits
    host_write(1'b1, 8'hFF);
    host_read(1'b1, 8'hED, "R5");
    expect_(K_DTR, 8'h01, "R11");
    expect_(K_SBRK, 8'h01, "R10");
    expect_(K_IRQ, 8'h00, "R6 tx");

    host_write(1'b1, 8'h80);
    expect_(K_IRQ, 8'h01, "R6 rx only");
    expect_(K_DTR, 8'h00, "R11");
    expect_(K_SBRK, 8'h00, "R10");
    ctl_load(8'h11);
    expect_(K_IRQ, 8'h00, "R6 rx");
    host_read(1'b0, 8'h11, "R3");
    expect_(K_IRQ, 8'h01, "R6 cleared");

    // R10/R11/R5: controller bits, read-only on host write
    rbrk = 1; dcd = 0; tick(3);
    host_read(1'b1, 8'h91, "R10 R11");
    host_write(1'b1, 8'h23);
    host_read(1'b1, 8'h11, "R5 ignored");
    rbrk = 0; dcd = 1; tick(3);

    // R9: held read, load during strobe
    ctl_load(8'h77);
    cs_n = 0; addr = 0; tick(1);
    rd_n = 0; tick(5);
    expect_(K_RXF, 8'h00, "R9 first");
    ctl_load(8'h88);
    tick(4);
    expect_(K_RXF, 8'h01, "R9 held");
    expect_(K_DOUT, 8'h88, "R9 dout");
    rd_n = 1; tick(1); cs_n = 1; tick(4);
    host_read(1'b1, 8'h23, "R9 status");

    tick(2);
    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule